// File: doc/BRIEF.md
# Calibrating SAR Conversion Sequencer

This block is the digital controller of one successive-approximation converter section. Once launched, it runs a fixed frame of 16 clock cycles and repeats that frame without further prompting. Each frame opens with three calibration cycles. The first samples a zero reference. The second compares that zero against the comparator and nudges an offset trim integrator. The third runs a gain-error comparison and nudges a gain trim integrator. The frame then samples the analog input and resolves 11 bits, most significant first, one bit per cycle. The last cycle hands the finished code out with a transfer strobe.

The analog comparator, the capacitive DAC and the reference ladder sit outside the block. The block drives the trial code that the DAC would convert, plus the control strobes that gate the analog switches, and it reads back a single comparator decision every cycle. The two trim codes are signed, saturating up/down counters that the analog side turns into correction voltages. A start strobe lets a parent align the frames of several interleaved sections; it launches an idle section or pulls a running one back to the frame's first cycle.

Top module: `sar_cal_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), every strobe, `dac_code`, `result` and both trims are zero, and the sequencer is idle.
- R2: When idle, the sequencer produces no strobes until `start` is sampled high. The cycle after a `start` edge is frame cycle 1. Frames then repeat every 16 cycles. A `start` seen in any running cycle makes the next cycle frame cycle 1.
- R3: Within a frame, `ref_zero_smp` is high in cycle 1, `az_cmp` in cycle 2, `cal_cmp` in cycle 3, `in_smp` in cycle 4 and `result_vld` in cycle 16. At most one of these strobes is high in any cycle.
- R4: In cycles 5 to 15, `dac_code` shows the trial code. In cycle 5 it is 0x400 (bit 10 alone set). In each search cycle, testing bit b, the tested bit stays set if `cmp` is 1 and is cleared if `cmp` is 0, and bit b-1 is set for the next cycle. Outside cycles 5 to 15, `dac_code` is 0.
- R5: In cycle 16, `result` holds the code resolved in cycles 5 to 15, which is 12 cycles after the `in_smp` cycle. `result` changes only at the edge that opens a `result_vld` cycle.
- R6: At the edge that ends cycle 2, `ofs_trim` (two's complement, 6 bits) steps +1 if `cmp` is 1 and -1 if `cmp` is 0. It saturates at +31 and -32.
- R7: At the edge that ends cycle 3, `gain_trim` (two's complement, 6 bits) steps +1 if `cmp` is 1 and -1 if `cmp` is 0. It saturates at +31 and -32.
- R8: `cmp` has no effect in cycles 1, 4 and 16 or while idle: neither trim, the trial code nor the result changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| start | input | 1 | Launch or realign the frame: the next cycle is frame cycle 1 |
| cmp | input | 1 | Comparator decision, 1 = input above trial level / error positive |
| dac_code | output | 11 | Trial code for the DAC during the bit search, else 0 |
| ref_zero_smp | output | 1 | Sample the zero reference (cycle 1) |
| az_cmp | output | 1 | Offset comparison cycle (cycle 2) |
| cal_cmp | output | 1 | Gain calibration comparison cycle (cycle 3) |
| in_smp | output | 1 | Sample the analog input (cycle 4) |
| ofs_trim | output | 6 | Signed offset trim code |
| gain_trim | output | 6 | Signed gain trim code |
| result | output | 11 | Last resolved conversion code |
| result_vld | output | 1 | Transfer strobe (cycle 16) |

## Verification
On every cycle, the assertions check several properties. The strobes are mutually exclusive, and the offset comparison always follows a zero-reference sample. Each trim moves only in its own calibration cycle, by exactly one step, and sticks at its limits. The search always opens at 0x400, and a transfer strobe always comes 12 cycles after an input sample. The bench's scenarios show what the properties cannot. Against a behavioural comparator, converted codes match the applied levels at both ends of the range and at mid-scale. The trims converge on and then saturate toward far targets. A mid-frame start realigns the frame, and random comparator values in the ignored cycles leave all state untouched.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REFZ,
    PH_AZ,
    PH_CAL,
    PH_SMP,
    PH_BIT,
    PH_XFER
  } phase_e;
endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 11,
  localparam int FRAME = N_BITS + 5,
  localparam int SW = $clog2(FRAME),
  localparam int BW = $clog2(N_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output phase_e        phase,
  output logic [BW-1:0] bit_idx
);
  logic          run_q, run_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          ctl_en;

  // control state advances whenever running or being launched
  assign ctl_en = start | run_q;

  always_comb begin
    run_d  = run_q;
    slot_d = slot_q;
    if (start) begin
      run_d  = 1'b1;
      slot_d = '0;
    end else if (slot_q == SW'(FRAME - 1)) begin
      slot_d = '0;
    end else begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
    end else if (ctl_en) begin
      run_q  <= run_d;
      slot_q <= slot_d;
    end
  end

  always_comb begin
    if (!run_q) phase = PH_IDLE;
    else begin
      case (slot_q)
        SW'(0):         phase = PH_REFZ;
        SW'(1):         phase = PH_AZ;
        SW'(2):         phase = PH_CAL;
        SW'(3):         phase = PH_SMP;
        SW'(FRAME - 1): phase = PH_XFER;
        default:        phase = PH_BIT;
      endcase
    end
  end

  // bit under test: MSB in the first search slot
  assign bit_idx = BW'(N_BITS - 1) - BW'(slot_q - SW'(4));
endmodule

// File: rtl/sar_trim_integ.sv
module sar_trim_integ #(
  parameter int TRIM_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     up,
  output logic signed [TRIM_W-1:0] trim
);
  localparam logic signed [TRIM_W-1:0] TMAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic signed [TRIM_W-1:0] TMIN = {1'b1, {(TRIM_W-1){1'b0}}};

  logic signed [TRIM_W-1:0] trim_q, trim_d;

  always_comb begin
    trim_d = trim_q;
    if (up && trim_q != TMAX)       trim_d = trim_q + 1'b1;
    else if (!up && trim_q != TMIN) trim_d = trim_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  trim_q <= '0;
    else if (en) trim_q <= trim_d;
  end

  assign trim = trim_q;
endmodule

// File: rtl/sar_bit_search.sv
module sar_bit_search #(
  parameter int N_BITS = 11,
  localparam int BW = $clog2(N_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [BW-1:0]     bit_idx,
  input  logic              cmp,
  output logic [N_BITS-1:0] trial,
  output logic [N_BITS-1:0] result
);
  logic [N_BITS-1:0] trial_q, trial_d;
  logic [N_BITS-1:0] res_q;
  logic              res_en;

  always_comb begin
    trial_d = trial_q;
    if (load) begin
      trial_d = '0;
      trial_d[N_BITS-1] = 1'b1;
    end else if (step) begin
      trial_d[bit_idx] = cmp;
      if (bit_idx != '0) trial_d[bit_idx - 1'b1] = 1'b1;
    end
  end

  assign res_en = step && (bit_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      res_q   <= '0;
    end else begin
      if (load | step) trial_q <= trial_d;
      if (res_en)      res_q   <= trial_d;
    end
  end

  assign trial  = trial_q;
  assign result = res_q;
endmodule

// File: rtl/sar_cal_seq.sv
module sar_cal_seq
  import sar_seq_pkg::*;
#(
  parameter int N_BITS = 11,
  parameter int TRIM_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     cmp,
  output logic [N_BITS-1:0]        dac_code,
  output logic                     ref_zero_smp,
  output logic                     az_cmp,
  output logic                     cal_cmp,
  output logic                     in_smp,
  output logic signed [TRIM_W-1:0] ofs_trim,
  output logic signed [TRIM_W-1:0] gain_trim,
  output logic [N_BITS-1:0]        result,
  output logic                     result_vld
);
  localparam int BW = $clog2(N_BITS);
  localparam int N_TRIM = 2;

  phase_e            phase;
  logic [BW-1:0]     bit_idx;
  logic [N_BITS-1:0] trial;
  logic [N_TRIM-1:0] trim_en;
  logic signed [TRIM_W-1:0] trim_v [N_TRIM];

  sar_frame_timer #(.N_BITS(N_BITS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .phase   (phase),
    .bit_idx (bit_idx)
  );

  sar_bit_search #(.N_BITS(N_BITS)) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (phase == PH_SMP),
    .step    (phase == PH_BIT),
    .bit_idx (bit_idx),
    .cmp     (cmp),
    .trial   (trial),
    .result  (result)
  );

  // index 0: offset loop, index 1: gain loop
  assign trim_en[0] = (phase == PH_AZ);
  assign trim_en[1] = (phase == PH_CAL);

  for (genvar g = 0; g < N_TRIM; g++) begin : g_trim
    sar_trim_integ #(.TRIM_W(TRIM_W)) u_integ (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (trim_en[g]),
      .up    (cmp),
      .trim  (trim_v[g])
    );
  end

  assign ofs_trim     = trim_v[0];
  assign gain_trim    = trim_v[1];
  assign ref_zero_smp = (phase == PH_REFZ);
  assign az_cmp       = (phase == PH_AZ);
  assign cal_cmp      = (phase == PH_CAL);
  assign in_smp       = (phase == PH_SMP);
  assign result_vld   = (phase == PH_XFER);
  assign dac_code     = (phase == PH_BIT) ? trial : '0;
endmodule

// File: rtl/sar_cal_seq_chk.sv
module sar_cal_seq_chk #(
  parameter int N_BITS = 11,
  parameter int TRIM_W = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic                     cmp,
  input logic [N_BITS-1:0]        dac_code,
  input logic                     ref_zero_smp,
  input logic                     az_cmp,
  input logic                     cal_cmp,
  input logic                     in_smp,
  input logic signed [TRIM_W-1:0] ofs_trim,
  input logic signed [TRIM_W-1:0] gain_trim,
  input logic [N_BITS-1:0]        result,
  input logic                     result_vld
);
  localparam logic [TRIM_W-1:0] TMAX = {1'b0, {(TRIM_W-1){1'b1}}};
  localparam logic [TRIM_W-1:0] TMIN = {1'b1, {(TRIM_W-1){1'b0}}};
  localparam logic [N_BITS-1:0] MSB1 = {1'b1, {(N_BITS-1){1'b0}}};

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_zero_smp, az_cmp, cal_cmp, in_smp, result_vld}));

  a_r2_refz_then_az: assert property (@(posedge clk) disable iff (!rst_n)
    ref_zero_smp && !start |=> az_cmp);

  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    in_smp && !start |=> dac_code == MSB1);

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> $past(in_smp, 12));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_vld);

  a_r8_ofs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !az_cmp |=> $stable(ofs_trim));

  a_r8_gain_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_cmp |=> $stable(gain_trim));

  a_r6_ofs_up: assert property (@(posedge clk) disable iff (!rst_n)
    az_cmp && cmp && ofs_trim != TMAX |=> ofs_trim == $past(ofs_trim) + TRIM_W'(1));

  a_r6_ofs_sat: assert property (@(posedge clk) disable iff (!rst_n)
    az_cmp && !cmp && ofs_trim == TMIN |=> ofs_trim == TMIN);

  a_r7_gain_dn: assert property (@(posedge clk) disable iff (!rst_n)
    cal_cmp && !cmp && gain_trim != TMIN |=> gain_trim == $past(gain_trim) - TRIM_W'(1));

  a_r7_gain_sat: assert property (@(posedge clk) disable iff (!rst_n)
    cal_cmp && cmp && gain_trim == TMAX |=> gain_trim == TMAX);
endmodule

bind sar_cal_seq sar_cal_seq_chk #(.N_BITS(N_BITS), .TRIM_W(TRIM_W)) u_chk (.*);

// File: tb/sar_cal_seq_tb.sv
module sar_cal_seq_tb;
  logic clk = 1'b0;
  logic rst_n, start, cmp;
  logic [10:0] dac_code, result;
  logic ref_zero_smp, az_cmp, cal_cmp, in_smp, result_vld;
  logic signed [5:0] ofs_trim, gain_trim;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural reference state
  int m_run, m_slot, m_ofs, m_gain, m_trial, m_res;
  int vin, ofs_tgt, gain_tgt;

  always #10 clk = ~clk;

  sar_cal_seq u_dut (.*);

  task automatic model_reset();
    m_run = 0; m_slot = 0; m_ofs = 0; m_gain = 0; m_trial = 0; m_res = 0;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clamp(input int v);
    return (v > 31) ? 31 : ((v < -32) ? -32 : v);
  endfunction

  task automatic tick(input bit s, input bit r);
    int e_dac;
    @(negedge clk);
    vectors++;
    e_dac = (m_run && m_slot >= 4 && m_slot <= 14) ? m_trial : 0;
    chk(ref_zero_smp, m_run && m_slot == 0, "R3 ref_zero_smp");
    chk(az_cmp,       m_run && m_slot == 1, "R3 az_cmp");
    chk(cal_cmp,      m_run && m_slot == 2, "R3 cal_cmp");
    chk(in_smp,       m_run && m_slot == 3, "R3 in_smp");
    chk(result_vld,   m_run && m_slot == 15, "R5 result_vld");
    chk(dac_code,     e_dac, "R4 dac_code");
    chk(ofs_trim,     m_ofs, "R6 ofs_trim");
    chk(gain_trim,    m_gain, "R7 gain_trim");
    chk(result,       m_res, "R5 result");
    if (m_run && m_slot == 15) chk(result, vin, "R5 converted code vs applied level");
    // drive inputs for this cycle; comparator model
    start = s;
    rst_n = r;
    if (m_run && m_slot == 1)                     cmp = (ofs_tgt > m_ofs);
    else if (m_run && m_slot == 2)                cmp = (gain_tgt > m_gain);
    else if (m_run && m_slot >= 4 && m_slot <= 14) cmp = (vin >= m_trial);
    else                                          cmp = 1'($urandom); // R8: must be ignored
    // advance the reference
    if (!r) model_reset();
    else begin
      if (m_run) begin
        if (m_slot == 1) m_ofs  = clamp(m_ofs  + (cmp ? 1 : -1));
        if (m_slot == 2) m_gain = clamp(m_gain + (cmp ? 1 : -1));
        if (m_slot == 3) m_trial = 1024;
        if (m_slot >= 4 && m_slot <= 14) begin
          int b = 14 - m_slot;
          if (!cmp) m_trial = m_trial & ~(1 << b);
          if (b > 0) m_trial = m_trial | (1 << (b - 1));
          else       m_res = m_trial;
        end
      end
      if (s) begin m_run = 1; m_slot = 0; end
      else if (m_run) m_slot = (m_slot + 1) % 16;
    end
  endtask

  task automatic frames(input int n, input int level);
    vin = level;
    for (int i = 0; i < n * 16; i++) tick(1'b0, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmp = 1'b0;
    vin = 0; ofs_tgt = 3; gain_tgt = -2;
    model_reset();
    // R1: reset state
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
    // R2/R8: idle, no start, random cmp
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b1);
    // R2: launch
    vin = 1024;
    tick(1'b1, 1'b1);
    frames(2, 1024);
    frames(1, 0);
    frames(1, 2047);
    frames(1, 1023);
    frames(1, 1365);
    frames(1, 682);
    for (int i = 0; i < 4; i++) frames(1, int'($urandom_range(0, 2047)));
    // R6/R7: drive trims into saturation in both directions
    ofs_tgt = 100; gain_tgt = -100;
    frames(40, 300);
    ofs_tgt = -100; gain_tgt = 100;
    frames(70, 1800);
    ofs_tgt = 0; gain_tgt = 0;
    frames(2, 77);
    // R2: realign mid-frame (cycle 8)
    for (int i = 0; i < 7; i++) tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    frames(2, 1500);
    // R1: asynchronous reset mid-frame, then relaunch
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    frames(2, 5);
    tick(1'b0, 1'b1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule